// File: doc/BRIEF.md
# Serial Peripheral Shift Controller with Fault Detection

This block is an 8-bit serial shift engine that works either as the clocking master or as a selected slave on a four-wire serial bus. Software talks to it over a small address/write/read register bus. A one-entry transmit buffer feeds the shift register, and a one-entry receive buffer holds the last character that came in. Data moves most significant bit first. Input is sampled on the rising clock edge and output changes on the falling edge. The serial clock rests low. In master role the serial clock comes from a fixed divider of the system clock.

Two faults are detected. The first is a transmit underrun: there is no new byte ready when the engine needs one. What happens then depends on the role and on a two-bit frame code. A master whose frame code has its upper bit clear pauses the clock and waits for software. A master whose frame code has its upper bit set flags the fault and ends the frame. A slave flags the fault and sends a character of all ones. The second fault is a collision: another master pulls the select line low while this unit is a master with multi-master checking enabled. Each fault has a sticky status bit that is cleared by writing 1 to it. One interrupt line combines every status flag with its own enable bit.

Top module: `spi_err_ctrl`

## Requirements
- R1: After reset, the status register reads 0x01 (only the transmit-empty flag set), control reads 0, the interrupt is low, the select output is high, the serial clock output is low, and no pin drivers are enabled.
- R2: As master, the unit gives exactly 8 rising serial-clock edges per character. The bit on the data-out pin at each rising edge follows the transmit byte, MSB first. The byte received is the 8 bits sampled on the data-in pin at those rising edges, MSB first.
- R3: The receive-full flag (status bit 1) is set when a character completes. It is cleared by reading address 0, which returns the received byte.
- R4: Writing address 0 clears the transmit-empty flag (status bit 0). The flag is set again when the engine takes the byte.
- R5: As master with frame code 2'b10 or 2'b11, a character that completes while the transmit buffer is empty sets the underrun flag (status bit 2). The serial clock stops low and the select output goes high.
- R6: As master with frame code 2'b00, an empty buffer at the end of a character never sets the underrun flag. The clock is held low and the select output stays low until address 0 is written. Then the next character is sent.
- R7: As slave, a falling select input with an empty transmit buffer sets the underrun flag and sends 0xFF. With a byte loaded, that byte is sent and no flag is set. Either way the bits on the slave data-in pin are received.
- R8: When the unit is an enabled master with multi-master checking on and the select pin configured as input, a low select input sets the collision flag (status bit 3). It also turns off the clock and data-out drivers at once. With multi-master checking off, a low select input does nothing.
- R9: Writing 1 to an error bit at address 2 clears it. Writing 0 leaves it unchanged. A fault in the same cycle as a clearing write leaves the bit set.
- R10: The interrupt output is high exactly when some status flag and its enable bit (address 3, same bit positions as status) are both 1.
- R11: Address 1 is the control register and reads back as written: bit 0 enable, bit 1 master role, bit 2 multi-master checking, bit 3 select pin is output, bits 5:4 frame code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (reading address 0 consumes the received byte) |
| rd_data | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock input (slave role) |
| sck_o | output | 1 | Serial clock output (master role) |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_i | input | 1 | Slave data-in pin |
| mosi_o | output | 1 | Master data-out pin |
| mosi_oe | output | 1 | Master data-out driver enable |
| miso_i | input | 1 | Master data-in pin |
| miso_o | output | 1 | Slave data-out pin |
| miso_oe | output | 1 | Slave data-out driver enable |
| ss_i | input | 1 | Select input, active low |
| ss_o | output | 1 | Select output, active low |
| ss_oe | output | 1 | Select driver enable |

## Verification
Some properties are checked on every cycle. A master underrun in the abort frame codes must release the select line. A plain-frame master must never raise the underrun flag. A collision must drop the clock and data drivers. Error bits must obey set-over-clear and write-one-to-clear, and the interrupt may only fall after a bus access. Other behaviour only shows up across whole transfers that the bench runs: the order of serial bits, the received byte, the paused clock resuming after a late write, the all-ones character of a starved slave, and a collision being ignored when multi-master checking is off.

// File: rtl/spi_err_pkg.sv
package spi_err_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int N_ERR   = 2;
    localparam int N_FLAGS = N_ERR + 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_STAT = 2'd2,
        REG_IEN  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [1:0] frame;
        logic       ss_drive;
        logic       mm_check;
        logic       master;
        logic       enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SHIFT,
        ENG_HOLD
    } eng_state_e;

    localparam int ERR_UND = 0;
    localparam int ERR_COL = 1;

    function automatic logic frame_aborts(input logic [1:0] frame);
        return frame[1];
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_flags.sv
module spi_flags
    import spi_err_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_ERR-1:0]   err_set,
    input  logic               clr_en,
    input  logic [N_ERR-1:0]   clr_bits,
    input  logic               tx_empty,
    input  logic               rx_full,
    input  logic [N_FLAGS-1:0] ien,
    output logic [N_ERR-1:0]   err_q,
    output logic               irq
);
    genvar i;
    generate
        for (i = 0; i < N_ERR; i++) begin : g_err
            always_ff @(posedge clk) begin
                if (rst)                          err_q[i] <= 1'b0;
                else if (err_set[i])              err_q[i] <= 1'b1;
                else if (clr_en && clr_bits[i])   err_q[i] <= 1'b0;
            end
        end
    endgenerate

    logic [N_FLAGS-1:0] flags;
    assign flags = {err_q, rx_full, tx_empty};
    assign irq   = |(flags & ien);
endmodule

// File: rtl/spi_engine.sv
module spi_engine
    import spi_err_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_empty,
    input  logic              miso_i,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              ss_s,
    output logic              tx_take,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              und_set,
    output logic              col_set,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              mosi_o,
    output logic              mosi_oe,
    output logic              miso_o,
    output logic              miso_oe,
    output logic              ss_o,
    output logic              ss_oe
);
    localparam int CW   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BCW  = $clog2(DATA_W + 1);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);
    localparam logic [BCW-1:0] ALL_BITS = BCW'(DATA_W);

    eng_state_e        state;
    logic [CW-1:0]     cnt;
    logic              sck_q;
    logic [DATA_W-1:0] shreg;
    logic              smp;
    logic [BCW-1:0]    bitcnt;
    logic              sck_prev, ss_prev, und_pend;

    logic master_on, slave_on, collide, run_m;
    logic m_tick, m_last, m_start, m_reload, m_und;
    logic s_act, s_begin, s_rise, s_fall, s_last, s_next, s_late_und;

    always_comb begin
        master_on = ctrl.enable && ctrl.master;
        slave_on  = ctrl.enable && !ctrl.master;
        collide   = master_on && ctrl.mm_check && !ctrl.ss_drive && !ss_s;
        run_m     = master_on && !collide;

        m_tick   = run_m && (state == ENG_SHIFT) && (cnt == CW'(HALF_DIV - 1));
        m_last   = m_tick && sck_q && (bitcnt == LAST_BIT);
        m_start  = run_m && (state != ENG_SHIFT) && !tx_empty;
        m_reload = m_last && !tx_empty;
        m_und    = m_last && tx_empty && frame_aborts(ctrl.frame);

        s_act      = slave_on && !ss_s;
        s_begin    = s_act && ss_prev;
        s_rise     = s_act && !s_begin && sck_s && !sck_prev;
        s_fall     = s_act && !s_begin && !sck_s && sck_prev;
        s_last     = s_rise && (bitcnt == LAST_BIT);
        s_next     = s_fall && (bitcnt == ALL_BITS);
        s_late_und = s_rise && (bitcnt == '0) && und_pend;

        tx_take = m_start || m_reload || ((s_begin || s_next) && !tx_empty);
        und_set = m_und || (s_begin && tx_empty) || s_late_und;
        col_set = collide;
        rx_done = m_last || s_last;
        rx_byte = run_m ? {shreg[DATA_W-2:0], smp} : {shreg[DATA_W-2:0], mosi_s};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            cnt      <= '0;
            sck_q    <= 1'b0;
            shreg    <= '0;
            smp      <= 1'b0;
            bitcnt   <= '0;
            sck_prev <= 1'b0;
            ss_prev  <= 1'b1;
            und_pend <= 1'b0;
        end else begin
            sck_prev <= sck_s;
            ss_prev  <= ss_s;
            if (run_m) begin
                und_pend <= 1'b0;
                case (state)
                    ENG_SHIFT: begin
                        if (cnt == CW'(HALF_DIV - 1)) begin
                            cnt <= '0;
                            if (!sck_q) begin
                                sck_q <= 1'b1;
                                smp   <= miso_i;
                            end else begin
                                sck_q <= 1'b0;
                                if (bitcnt == LAST_BIT) begin
                                    bitcnt <= '0;
                                    if (!tx_empty)                    shreg <= tx_data;
                                    else if (frame_aborts(ctrl.frame)) state <= ENG_IDLE;
                                    else                               state <= ENG_HOLD;
                                end else begin
                                    shreg  <= {shreg[DATA_W-2:0], smp};
                                    bitcnt <= bitcnt + 1'b1;
                                end
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (!tx_empty) begin
                            shreg  <= tx_data;
                            bitcnt <= '0;
                            cnt    <= '0;
                            sck_q  <= 1'b0;
                            state  <= ENG_SHIFT;
                        end
                    end
                endcase
            end else begin
                state <= ENG_IDLE;
                sck_q <= 1'b0;
                cnt   <= '0;
                if (!s_act) begin
                    bitcnt   <= '0;
                    und_pend <= 1'b0;
                end else if (s_begin) begin
                    shreg    <= tx_empty ? '1 : tx_data;
                    bitcnt   <= '0;
                    und_pend <= 1'b0;
                end else if (s_rise) begin
                    smp      <= mosi_s;
                    bitcnt   <= bitcnt + 1'b1;
                    und_pend <= 1'b0;
                end else if (s_next) begin
                    shreg    <= tx_empty ? '1 : tx_data;
                    und_pend <= tx_empty;
                    bitcnt   <= '0;
                end else if (s_fall && bitcnt != '0) begin
                    shreg <= {shreg[DATA_W-2:0], smp};
                end
            end
        end
    end

    assign sck_o   = sck_q;
    assign sck_oe  = run_m;
    assign mosi_o  = shreg[DATA_W-1];
    assign mosi_oe = run_m;
    assign miso_o  = shreg[DATA_W-1];
    assign miso_oe = s_act;
    assign ss_oe   = master_on && ctrl.ss_drive;
    assign ss_o    = !(run_m && ctrl.ss_drive && state != ENG_IDLE);
endmodule

// File: rtl/spi_err_ctrl.sv
module spi_err_ctrl
    import spi_err_pkg::*;
#(
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              ss_i,
    output logic              ss_o,
    output logic              ss_oe
);
    ctrl_t              ctrl_q;
    logic [N_FLAGS-1:0] ien_q;
    logic [DATA_W-1:0]  tx_buf, rx_buf, rx_byte;
    logic               tx_empty_q, rx_full_q;
    logic               tx_take, rx_done, und_set, col_set;
    logic [N_ERR-1:0]   err_q, err_set;
    logic [2:0]         pins_s;
    logic               wr_data_sel, wr_ctrl_sel, wr_stat_sel, wr_ien_sel, rd_data_sel;

    assign wr_data_sel = wr_en && (addr == REG_DATA);
    assign wr_ctrl_sel = wr_en && (addr == REG_CTRL);
    assign wr_stat_sel = wr_en && (addr == REG_STAT);
    assign wr_ien_sel  = wr_en && (addr == REG_IEN);
    assign rd_data_sel = rd_en && (addr == REG_DATA);

    spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_i, sck_i, mosi_i}),
        .q   (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            ien_q      <= '0;
            tx_buf     <= '0;
            tx_empty_q <= 1'b1;
            rx_buf     <= '0;
            rx_full_q  <= 1'b0;
        end else begin
            if (wr_ctrl_sel) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_ien_sel)  ien_q  <= wr_data[N_FLAGS-1:0];
            if (wr_data_sel) begin
                tx_buf     <= wr_data;
                tx_empty_q <= 1'b0;
            end else if (tx_take) begin
                tx_empty_q <= 1'b1;
            end
            if (rx_done) begin
                rx_buf    <= rx_byte;
                rx_full_q <= 1'b1;
            end else if (rd_data_sel) begin
                rx_full_q <= 1'b0;
            end
        end
    end

    spi_engine #(.HALF_DIV(HALF_DIV)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_q),
        .tx_data  (tx_buf),
        .tx_empty (tx_empty_q),
        .miso_i   (miso_i),
        .sck_s    (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .ss_s     (pins_s[2]),
        .tx_take  (tx_take),
        .rx_done  (rx_done),
        .rx_byte  (rx_byte),
        .und_set  (und_set),
        .col_set  (col_set),
        .sck_o    (sck_o),
        .sck_oe   (sck_oe),
        .mosi_o   (mosi_o),
        .mosi_oe  (mosi_oe),
        .miso_o   (miso_o),
        .miso_oe  (miso_oe),
        .ss_o     (ss_o),
        .ss_oe    (ss_oe)
    );

    always_comb begin
        err_set          = '0;
        err_set[ERR_UND] = und_set;
        err_set[ERR_COL] = col_set;
    end

    spi_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .err_set  (err_set),
        .clr_en   (wr_stat_sel),
        .clr_bits (wr_data[N_FLAGS-1:2]),
        .tx_empty (tx_empty_q),
        .rx_full  (rx_full_q),
        .ien      (ien_q),
        .err_q    (err_q),
        .irq      (irq)
    );

    always_comb begin
        case (addr)
            REG_DATA: rd_data = rx_buf;
            REG_CTRL: rd_data = DATA_W'(ctrl_q);
            REG_STAT: rd_data = DATA_W'({err_q, rx_full_q, tx_empty_q});
            default:  rd_data = DATA_W'(ien_q);
        endcase
    end
endmodule

// File: rtl/spi_err_ctrl_chk.sv
module spi_err_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       rd_en,
    input logic       irq,
    input logic       ss_o,
    input logic       sck_oe,
    input logic       mosi_oe,
    input logic [5:0] ctrl,
    input logic       und_set,
    input logic       col_set,
    input logic [1:0] err_q
);
    logic master_en, stat_wr;
    assign master_en = ctrl[0] && ctrl[1];
    assign stat_wr   = wr_en && (addr == 2'd2);

    // R5
    und_release_ss_chk: assert property (@(posedge clk) disable iff (rst)
        (und_set && master_en && ctrl[3]) |=> ss_o);

    // R6
    plain_no_und_chk: assert property (@(posedge clk) disable iff (rst)
        (master_en && ctrl[5:4] == 2'b00 && !err_q[0]) |=> !err_q[0]);

    // R8
    col_drop_drv_chk: assert property (@(posedge clk) disable iff (rst)
        col_set |-> (!sck_oe && !mosi_oe));

    // R9
    col_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        col_set |=> err_q[1]);

    // R9
    und_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        und_set |=> err_q[0]);

    // R9
    col_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && wr_data[3] && !col_set) |=> !err_q[1]);

    // R9
    col_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q[1] && !(stat_wr && wr_data[3])) |=> err_q[1]);

    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(wr_en || rd_en));
endmodule

bind spi_err_ctrl spi_err_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .irq     (irq),
    .ss_o    (ss_o),
    .sck_oe  (sck_oe),
    .mosi_oe (mosi_oe),
    .ctrl    (ctrl_q),
    .und_set (und_set),
    .col_set (col_set),
    .err_q   (err_q)
);

// File: tb/spi_err_ctrl_bench.sv
`timescale 1ns/100ps
module spi_err_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0, rd_data;
    logic       irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_i = 1'b1;
    logic       miso_i;

    int checks = 0, fails = 0;
    logic [7:0] slv_tx = '0, cap = '0;
    logic [2:0] slv_idx = '0;
    int         rises = 0;
    logic       sck_seen = 1'b0;

    always #2.5 clk = ~clk;

    spi_err_ctrl u_spi_err_ctrl (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq(irq),
        .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ss_i(ss_i), .ss_o(ss_o), .ss_oe(ss_oe)
    );

    // behavioural slave for master-role tests
    assign miso_i = slv_tx[~slv_idx];
    always @(negedge clk) begin
        if (sck_o && !sck_seen) begin
            cap   = {cap[6:0], mosi_o};
            rises = rises + 1;
        end
        if (!sck_o && sck_seen) slv_idx = slv_idx + 1'b1;
        sck_seen = sck_o;
    end

    function automatic logic [7:0] ctrl_word(input logic [1:0] frame, input logic ss_drv,
                                             input logic mm, input logic mst, input logic en);
        return {2'b00, frame, ss_drv, mm, mst, en};
    endfunction

    function automatic logic [7:0] slave_expect(input logic loaded, input logic [7:0] d);
        return loaded ? d : 8'hFF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_rx();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd2, s);
            if (s[1]) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic master_abort(input logic [1:0] frame, input logic [7:0] a, input logic [7:0] b);
        logic [7:0] s, r;
        wr(2'd1, ctrl_word(frame, 1'b1, 1'b0, 1'b1, 1'b0));
        slv_tx = b; slv_idx = '0; cap = '0; rises = 0;
        wr(2'd0, a);
        rd(2'd2, s);
        check("R4 tx empty cleared by write", 32'(s[0]), 32'd0);
        wr(2'd1, ctrl_word(frame, 1'b1, 1'b0, 1'b1, 1'b1));
        wait_rx();
        idle(10);
        check("R2 mosi byte", 32'(cap), 32'(a));
        check("R2 rising edges", rises, 8);
        rd(2'd2, s);
        check("R5 underrun flag", 32'(s[2]), 32'd1);
        check("R4 tx empty after take", 32'(s[0]), 32'd1);
        check("R5 select released", 32'(ss_o), 32'd1);
        idle(40);
        check("R5 clock stopped", rises, 8);
        check("R5 clock low", 32'(sck_o), 32'd0);
        rd(2'd0, r);
        check("R2 received byte", 32'(r), 32'(b));
        rd(2'd2, s);
        check("R3 rx full cleared by read", 32'(s[1]), 32'd0);
        wr(2'd2, 8'h04);
        rd(2'd2, s);
        check("R9 underrun cleared by W1C", 32'(s[2]), 32'd0);
    endtask

    task automatic slave_xfer(input logic loaded, input logic [7:0] d, input logic [7:0] m);
        logic [7:0] s, r, got;
        got = '0;
        wr(2'd1, ctrl_word(2'b00, 1'b0, 1'b0, 1'b0, 1'b1));
        if (loaded) wr(2'd0, d);
        ss_i = 1'b0;
        idle(8);
        check("R7 slave drives miso", 32'(miso_oe), 32'd1);
        for (int k = 0; k < 8; k++) begin
            mosi_i = m[7-k];
            idle(8);
            got = {got[6:0], miso_o};
            sck_i = 1'b1;
            idle(8);
            sck_i = 1'b0;
        end
        idle(8);
        ss_i = 1'b1;
        idle(6);
        check("R7 slave sent byte", 32'(got), 32'(slave_expect(loaded, d)));
        rd(2'd2, s);
        check("R7 slave underrun flag", 32'(s[2]), 32'(!loaded));
        check("R3 rx full after slave char", 32'(s[1]), 32'd1);
        rd(2'd0, r);
        check("R7 slave received byte", 32'(r), 32'(m));
        wr(2'd2, 8'h04);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] s, r, a, b;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(2'd2, s);
        check("R1 status", 32'(s), 32'h01);
        rd(2'd1, s);
        check("R1 control", 32'(s), 32'h00);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 ss_o", 32'(ss_o), 32'd1);
        check("R1 sck_o", 32'(sck_o), 32'd0);
        check("R1 drivers", 32'({sck_oe, mosi_oe, miso_oe, ss_oe}), 32'd0);

        // R11 control readback
        wr(2'd1, 8'h3A);
        rd(2'd1, s);
        check("R11 control readback", 32'(s), 32'h3A);
        wr(2'd1, 8'h00);

        // R10 interrupt combine
        wr(2'd3, 8'h01);
        check("R10 irq on tx empty", 32'(irq), 32'd1);
        wr(2'd3, 8'h00);
        check("R10 irq masked", 32'(irq), 32'd0);

        // directed + random abort-frame master transfers
        master_abort(2'b10, 8'hA5, 8'h3C);
        for (int it = 0; it < 6; it++) begin
            a = 8'($urandom);
            b = 8'($urandom);
            master_abort(($urandom % 2) ? 2'b11 : 2'b10, a, b);
        end

        // R6 plain frame pauses and resumes
        wr(2'd3, 8'h04);
        wr(2'd1, ctrl_word(2'b00, 1'b1, 1'b0, 1'b1, 1'b1));
        slv_tx = 8'h96; slv_idx = '0; cap = '0; rises = 0;
        wr(2'd0, 8'h5E);
        wait_rx();
        idle(60);
        rd(2'd2, s);
        check("R6 no underrun", 32'(s[2]), 32'd0);
        check("R6 irq stays low", 32'(irq), 32'd0);
        check("R6 select held", 32'(ss_o), 32'd0);
        check("R6 clock held low", 32'(sck_o), 32'd0);
        check("R6 paused after one char", rises, 8);
        rd(2'd0, r);
        check("R6 first rx", 32'(r), 32'h96);
        wr(2'd0, 8'hC3);
        wait_rx();
        idle(4);
        check("R6 resumed char", 32'(cap), 32'hC3);
        check("R6 edges total", rises, 16);
        rd(2'd0, r);
        check("R6 second rx", 32'(r), 32'h96);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h00);

        // R8 collision
        wr(2'd3, 8'h08);
        wr(2'd1, ctrl_word(2'b00, 1'b0, 1'b1, 1'b1, 1'b1));
        ss_i = 1'b0;
        idle(6);
        rd(2'd2, s);
        check("R8 collision flag", 32'(s[3]), 32'd1);
        check("R8 clock driver off", 32'(sck_oe), 32'd0);
        check("R8 data driver off", 32'(mosi_oe), 32'd0);
        check("R10 irq on collision", 32'(irq), 32'd1);
        ss_i = 1'b1;
        idle(6);
        wr(2'd2, 8'h00);
        rd(2'd2, s);
        check("R9 write 0 keeps collision", 32'(s[3]), 32'd1);
        wr(2'd2, 8'h08);
        rd(2'd2, s);
        check("R9 collision cleared", 32'(s[3]), 32'd0);
        check("R10 irq cleared", 32'(irq), 32'd0);
        wr(2'd1, ctrl_word(2'b00, 1'b0, 1'b0, 1'b1, 1'b1));
        ss_i = 1'b0;
        idle(6);
        rd(2'd2, s);
        check("R8 no collision when checking off", 32'(s[3]), 32'd0);
        check("R8 clock driver kept", 32'(sck_oe), 32'd1);
        ss_i = 1'b1;
        idle(6);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'h00);

        // R7 slave role
        slave_xfer(1'b1, 8'h81, 8'h7E);
        slave_xfer(1'b0, 8'h00, 8'h42);
        for (int it = 0; it < 3; it++) begin
            a = 8'($urandom);
            b = 8'($urandom);
            slave_xfer(1'($urandom % 2), a, b);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule